// File: doc/BRIEF.md
# SD Data Block Transfer Engine

This engine moves a burst of equal-sized data blocks between a local byte buffer and the SD card data lines. It runs in 1-bit or 4-bit bus width. A transfer is launched by a one-cycle start strobe together with a direction, a width, a per-block line-bit count, a block repeat count and a write gap. The engine advances one bit time per clock. The clock-enable that sets the card clock rate lies outside this block.

In a read, the engine waits for the card's start bit before each block. It unpacks the line bits into bytes and writes them to the buffer at consecutive addresses. It then compares the trailing CRC16 of every active line with the value it computed itself. In a write, the engine fetches bytes from the buffer and frames each block with an idle gap, a start bit, the data, a CRC16 per line and an end bit. It then releases the lines, reads the card's three-bit status token and waits until the card stops holding DAT0 low before it sends the next block. The engine reports read and write CRC status on separate outputs when the transfer ends. The buffer port is a plain address/data interface, not a bus master.

Top module: `sdb_xfer_engine`

## Requirements
- R1: After a synchronous reset the engine is idle. `busy`, `done`, `dat_oe`, `buf_we`, `rd_crc_ok` and `wr_crc_ok` are all 0.
- R2: The block length in bytes is taken as (`cfg_line_bits` − 15 × active lines) / 8, where the active lines are 1 when `cfg_wide`=0 and 4 when `cfg_wide`=1. The number of blocks is `cfg_repeat` + 1. Block lengths up to 512 bytes are supported.
- R3: Bit order. In 1-bit mode each byte goes out (or comes in) MSB first on `dat[0]`. In 4-bit mode the high nibble comes first, and `dat[i]` carries bit i of the nibble, so `dat[3]` holds the nibble MSB.
- R4: Each write block is framed as follows: max(`cfg_wgap`,1) clocks of 1, one start bit of 0, the data, 16 CRC bits, then one end bit of 1. For the whole frame `dat_oe` is 4'b0001 in 1-bit mode and 4'b1111 in 4-bit mode. At all other times `dat_oe` is 0.
- R5: Each active line carries its own CRC16, with polynomial x^16+x^12+x^5+1, start value 0, computed over that line's data bits and sent MSB first.
- R6: After the end bit of a write block the engine drives no line. It waits for `dat_in[0]`=0, samples three token bits MSB first, skips one end bit, and then waits for `dat_in[0]`=1 before it begins the next block's gap.
- R7: When a write ends, `wr_crc_ok` is 1 only if every token equalled 3'b010. `rd_crc_ok` stays 0 after a write.
- R8: A read waits for `dat_in[0]`=0 before each block. Each completed byte gives a one-cycle `buf_we` pulse. The write addresses run 0, 1, 2, … across all blocks. `buf_we` never pulses in a write transfer.
- R9: When a read ends, `rd_crc_ok` is 1 only if every received CRC bit matched on every active line. `wr_crc_ok` stays 0 after a read.
- R10: `busy` rises on the clock after an accepted start. In the cycle after the last block completes, `done` pulses for exactly one cycle and `busy` falls. A start clears both status bits.
- R11: While `busy` is 1, `start` and all configuration inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| cfg_read | input | 1 | 1 = card to buffer, 0 = buffer to card |
| cfg_wide | input | 1 | 0 = 1-bit bus, 1 = 4-bit bus |
| cfg_line_bits | input | LBITS_W | Block bytes × 8 + 15 × active lines |
| cfg_repeat | input | CNT_W | Number of blocks minus one |
| cfg_wgap | input | GAP_W | Idle clocks before each write block |
| buf_raddr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, combinational from buf_raddr |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| dat_in | input | 4 | Sampled DAT lines |
| dat_out | output | 4 | Driven DAT values |
| dat_oe | output | 4 | Per-line drive enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_crc_ok | output | 1 | All read CRCs matched |
| wr_crc_ok | output | 1 | All write tokens accepted |

## Verification
The bench builds the engine with MAX_BLK_BYTES=512, CNT_W=4, ADDR_W=11 and GAP_W=4. This makes a full 512-byte block in 4-bit mode reachable, along with multi-block bursts and gap values of 0, 2 and 3. In every write the expected DAT waveform is rebuilt bit by bit from the buffer contents and compared on each clock. The bench acts as the card: it answers with good or rejecting tokens and holds busy for several cycles. Reads feed framed blocks, some with a flipped CRC bit on one line. One write is hit by a mid-transfer start carrying a different direction and width.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int LANES = 4;
    localparam logic [15:0] CRC16_POLY = 16'h1021;
    localparam logic [2:0]  TOKEN_ACCEPT = 3'b010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RWAIT,
        S_RDATA,
        S_RCRC,
        S_REND,
        S_WGAP,
        S_WSTART,
        S_WDATA,
        S_WCRC,
        S_WEND,
        S_TWAIT,
        S_TBITS,
        S_TEND,
        S_WBUSY
    } sdb_state_e;

    typedef struct packed {
        logic rd;
        logic wide;
    } sdb_mode_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic [15:0] sh;
        sh = {c[14:0], 1'b0};
        return (b ^ c[15]) ? (sh ^ CRC16_POLY) : sh;
    endfunction

endpackage

// File: rtl/sdb_crc_bank.sv
module sdb_crc_bank
    import sdb_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              feed,
    input  logic              shift,
    input  logic [NLANES-1:0] bits,
    output logic [NLANES-1:0] msb
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [15:0] crc_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                crc_q <= '0;
            end else if (feed) begin
                crc_q <= crc16_step(crc_q, bits[g]);
            end else if (shift) begin
                crc_q <= {crc_q[14:0], 1'b0};
            end
        end

        assign msb[g] = crc_q[15];
    end

endmodule

// File: rtl/sdb_nibble_shift.sv
module sdb_nibble_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       shift,
    input  logic       wide,
    input  logic [7:0] ldata,
    input  logic [3:0] din,
    output logic [3:0] sym_out,
    output logic [7:0] byte_next
);

    logic [7:0] sh_q;

    // Incoming bits enter at the bottom; outgoing bits leave from the top.
    assign byte_next = wide ? {sh_q[3:0], din} : {sh_q[6:0], din[0]};
    assign sym_out   = wide ? sh_q[7:4] : {3'b111, sh_q[7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= ldata;
        end else if (shift) begin
            sh_q <= byte_next;
        end
    end

endmodule

// File: rtl/sdb_xfer_engine.sv
module sdb_xfer_engine
    import sdb_pkg::*;
#(
    parameter int MAX_BLK_BYTES = 512,
    parameter int CNT_W         = 9,
    parameter int ADDR_W        = 16,
    parameter int GAP_W         = 4,
    localparam int LBITS_W      = $clog2(MAX_BLK_BYTES * 8 + 61),
    localparam int BYTE_W       = $clog2(MAX_BLK_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cfg_read,
    input  logic               cfg_wide,
    input  logic [LBITS_W-1:0] cfg_line_bits,
    input  logic [CNT_W-1:0]   cfg_repeat,
    input  logic [GAP_W-1:0]   cfg_wgap,
    output logic [ADDR_W-1:0]  buf_raddr,
    input  logic [7:0]         buf_rdata,
    output logic               buf_we,
    output logic [ADDR_W-1:0]  buf_waddr,
    output logic [7:0]         buf_wdata,
    input  logic [3:0]         dat_in,
    output logic [3:0]         dat_out,
    output logic [3:0]         dat_oe,
    output logic               busy,
    output logic               done,
    output logic               rd_crc_ok,
    output logic               wr_crc_ok
);

    localparam int AUX_W = (GAP_W > 4) ? GAP_W : 4;

    sdb_state_e          state;
    sdb_mode_t           mode_q;
    logic [BYTE_W-1:0]   blk_bytes;
    logic [BYTE_W-1:0]   byte_cnt;
    logic [CNT_W-1:0]    blk_left;
    logic [GAP_W-1:0]    gap_q;
    logic [ADDR_W-1:0]   ptr;
    logic [2:0]          bit_cnt;
    logic [AUX_W-1:0]    aux;
    logic [1:0]          tok;
    logic                err, done_q, rd_ok, wr_ok, we_q;
    logic [ADDR_W-1:0]   waddr_q;
    logic [7:0]          wdata_q;

    logic [LBITS_W-1:0]  ovh;
    logic [3:0]          act;
    logic                byte_last, blk_last_byte, in_wframe;
    logic [3:0]          sym_out, crc_msb, crc_bits;
    logic [7:0]          byte_next;
    logic                sh_load, sh_shift;

    assign ovh           = cfg_wide ? LBITS_W'(60) : LBITS_W'(15);
    assign act           = mode_q.wide ? 4'hF : 4'h1;
    assign byte_last     = (bit_cnt == (mode_q.wide ? 3'd1 : 3'd7));
    assign blk_last_byte = (byte_cnt == blk_bytes - BYTE_W'(1));
    assign in_wframe     = state inside {S_WGAP, S_WSTART, S_WDATA, S_WCRC, S_WEND};

    assign sh_load  = (state == S_WSTART) || ((state == S_WDATA) && byte_last);
    assign sh_shift = ((state == S_WDATA) && !byte_last) || (state == S_RDATA);
    assign crc_bits = (state == S_WDATA) ? sym_out : dat_in;

    sdb_nibble_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .shift     (sh_shift),
        .wide      (mode_q.wide),
        .ldata     (buf_rdata),
        .din       (dat_in),
        .sym_out   (sym_out),
        .byte_next (byte_next)
    );

    sdb_crc_bank #(.NLANES(LANES)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .clr   ((state == S_WGAP) || (state == S_RWAIT)),
        .feed  ((state == S_WDATA) || (state == S_RDATA)),
        .shift ((state == S_WCRC) || (state == S_RCRC)),
        .bits  (crc_bits),
        .msb   (crc_msb)
    );

    always_comb begin
        case (state)
            S_WSTART: dat_out = 4'h0;
            S_WDATA:  dat_out = sym_out;
            S_WCRC:   dat_out = crc_msb;
            default:  dat_out = 4'hF;
        endcase
        dat_oe = in_wframe ? act : 4'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            mode_q    <= '0;
            blk_bytes <= '0;
            byte_cnt  <= '0;
            blk_left  <= '0;
            gap_q     <= '0;
            ptr       <= '0;
            bit_cnt   <= '0;
            aux       <= '0;
            tok       <= '0;
            err       <= 1'b0;
            done_q    <= 1'b0;
            rd_ok     <= 1'b0;
            wr_ok     <= 1'b0;
            we_q      <= 1'b0;
            waddr_q   <= '0;
            wdata_q   <= '0;
        end else begin
            done_q <= 1'b0;
            we_q   <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    mode_q    <= '{rd: cfg_read, wide: cfg_wide};
                    blk_bytes <= BYTE_W'((cfg_line_bits - ovh) >> 3);
                    blk_left  <= cfg_repeat;
                    gap_q     <= cfg_wgap;
                    rd_ok     <= 1'b0;
                    wr_ok     <= 1'b0;
                    err       <= 1'b0;
                    ptr       <= '0;
                    aux       <= '0;
                    state     <= cfg_read ? S_RWAIT : S_WGAP;
                end
                S_RWAIT: if (!dat_in[0]) begin
                    bit_cnt  <= '0;
                    byte_cnt <= '0;
                    state    <= S_RDATA;
                end
                S_RDATA: begin
                    bit_cnt <= bit_cnt + 3'd1;
                    if (byte_last) begin
                        bit_cnt  <= '0;
                        we_q     <= 1'b1;
                        wdata_q  <= byte_next;
                        waddr_q  <= ptr;
                        ptr      <= ptr + ADDR_W'(1);
                        byte_cnt <= byte_cnt + BYTE_W'(1);
                        if (blk_last_byte) begin
                            aux   <= '0;
                            state <= S_RCRC;
                        end
                    end
                end
                S_RCRC: begin
                    aux <= aux + AUX_W'(1);
                    if (((crc_msb ^ dat_in) & act) != 4'h0) err <= 1'b1;
                    if (aux == AUX_W'(15)) state <= S_REND;
                end
                S_REND: begin
                    if (blk_left == '0) begin
                        rd_ok  <= !err;
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        blk_left <= blk_left - CNT_W'(1);
                        state    <= S_RWAIT;
                    end
                end
                S_WGAP: begin
                    aux <= aux + AUX_W'(1);
                    if ((AUX_W + 1)'(aux) + (AUX_W + 1)'(1) >= (AUX_W + 1)'(gap_q))
                        state <= S_WSTART;
                end
                S_WSTART: begin
                    ptr      <= ptr + ADDR_W'(1);
                    bit_cnt  <= '0;
                    byte_cnt <= '0;
                    state    <= S_WDATA;
                end
                S_WDATA: begin
                    bit_cnt <= bit_cnt + 3'd1;
                    if (byte_last) begin
                        bit_cnt  <= '0;
                        byte_cnt <= byte_cnt + BYTE_W'(1);
                        if (blk_last_byte) begin
                            aux   <= '0;
                            state <= S_WCRC;
                        end else begin
                            ptr <= ptr + ADDR_W'(1);
                        end
                    end
                end
                S_WCRC: begin
                    aux <= aux + AUX_W'(1);
                    if (aux == AUX_W'(15)) state <= S_WEND;
                end
                S_WEND:  state <= S_TWAIT;
                S_TWAIT: if (!dat_in[0]) begin
                    aux   <= '0;
                    state <= S_TBITS;
                end
                S_TBITS: begin
                    tok <= {tok[0], dat_in[0]};
                    aux <= aux + AUX_W'(1);
                    if (aux == AUX_W'(2)) begin
                        if ({tok, dat_in[0]} != TOKEN_ACCEPT) err <= 1'b1;
                        state <= S_TEND;
                    end
                end
                S_TEND:  state <= S_WBUSY;
                S_WBUSY: if (dat_in[0]) begin
                    if (blk_left == '0) begin
                        wr_ok  <= !err;
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        blk_left <= blk_left - CNT_W'(1);
                        aux      <= '0;
                        state    <= S_WGAP;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign buf_raddr = ptr;
    assign buf_we    = we_q;
    assign buf_waddr = waddr_q;
    assign buf_wdata = wdata_q;
    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign rd_crc_ok = rd_ok;
    assign wr_crc_ok = wr_ok;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mode_q));

    // R8
    we_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> mode_q.rd);

    // R4
    oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_oe == 4'h0) || ((dat_oe == act) && !mode_q.rd));

    // R7
    status_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_crc_ok && wr_crc_ok));

endmodule

// File: tb/sdb_xfer_engine_bench.sv
module sdb_xfer_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB    = 512;
    localparam int CNT_W   = 4;
    localparam int ADDR_W  = 11;
    localparam int GAP_W   = 4;
    localparam int LBITS_W = $clog2(MAXB * 8 + 61);
    localparam int MEM_N   = 1 << ADDR_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               cfg_read = 1'b0;
    logic               cfg_wide = 1'b0;
    logic [LBITS_W-1:0] cfg_line_bits = '0;
    logic [CNT_W-1:0]   cfg_repeat = '0;
    logic [GAP_W-1:0]   cfg_wgap = '0;
    logic [ADDR_W-1:0]  buf_raddr, buf_waddr;
    logic [7:0]         buf_rdata, buf_wdata;
    logic               buf_we;
    logic [3:0]         dat_in = 4'hF;
    logic [3:0]         dat_out, dat_oe;
    logic               busy, done, rd_crc_ok, wr_crc_ok;

    logic [7:0] src_mem [MEM_N];
    int errors = 0;
    int checks = 0;
    int wr_seen = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign buf_rdata = src_mem[buf_raddr];

    sdb_xfer_engine #(
        .MAX_BLK_BYTES(MAXB), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .GAP_W(GAP_W)
    ) u_sdb_xfer_engine (
        .clk(clk), .rst(rst), .start(start), .cfg_read(cfg_read), .cfg_wide(cfg_wide),
        .cfg_line_bits(cfg_line_bits), .cfg_repeat(cfg_repeat), .cfg_wgap(cfg_wgap),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .dat_in(dat_in),
        .dat_out(dat_out), .dat_oe(dat_oe), .busy(busy), .done(done),
        .rd_crc_ok(rd_crc_ok), .wr_crc_ok(wr_crc_ok)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Line symbol idx of a block starting at base (R3 ordering)
    function automatic logic [3:0] data_sym(input bit wide, input int base, input int idx);
        logic [7:0] by;
        if (wide) begin
            by = src_mem[base + idx / 2];
            return (idx % 2 == 0) ? by[7:4] : by[3:0];
        end
        by = src_mem[base + idx / 8];
        return {3'b111, by[7 - idx % 8]};
    endfunction

    // R5 reference CRC16 of one line
    function automatic logic [15:0] ref_crc(input int lane, input bit wide,
                                            input int base, input int nbytes);
        logic [15:0] c = '0;
        int nsym = wide ? nbytes * 2 : nbytes * 8;
        for (int i = 0; i < nsym; i++) begin
            logic [3:0] s;
            logic b;
            s = data_sym(wide, base, i);
            b = s[lane];
            c = (b ^ c[15]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic do_write(input bit wide, input int bytes, input int nblk,
                            input int gap, input int bad_blk, input bit poke);
        logic [3:0]  act = wide ? 4'hF : 4'h1;
        int          nsym = wide ? bytes * 2 : bytes * 8;
        int          gaps = (gap < 1) ? 1 : gap;
        int          total = gaps + 1 + nsym + 16 + 1;
        logic [15:0] c [4];
        logic [3:0]  e;
        logic [2:0]  tok;
        string       tag;
        @(negedge clk);
        cfg_read = 1'b0;
        cfg_wide = wide;
        cfg_line_bits = LBITS_W'(bytes * 8 + 15 * (wide ? 4 : 1));
        cfg_repeat = CNT_W'(nblk - 1);
        cfg_wgap = GAP_W'(gap);
        start = 1'b1;
        dat_in = 4'hF;
        for (int b = 0; b < nblk; b++) begin
            for (int l = 0; l < 4; l++) c[l] = ref_crc(l, wide, b * bytes, bytes);
            for (int i = 0; i < total; i++) begin
                @(negedge clk);
                if (b == 0 && i == 0) start = 1'b0;
                if (poke && b == 0 && i == 5) begin
                    start = 1'b1; cfg_read = 1'b1; cfg_wide = ~wide;
                end
                if (poke && b == 0 && i == 6) begin
                    start = 1'b0; cfg_read = 1'b0; cfg_wide = wide;
                end
                if (i < gaps) begin
                    e = 4'hF; tag = "R4 gap";
                end else if (i == gaps) begin
                    e = 4'h0; tag = "R4 start";
                end else if (i <= gaps + nsym) begin
                    e = data_sym(wide, b * bytes, i - gaps - 1); tag = "R3 data";
                end else if (i <= gaps + nsym + 16) begin
                    for (int l = 0; l < 4; l++) e[l] = c[l][15 - (i - gaps - nsym - 1)];
                    tag = "R5 crc";
                end else begin
                    e = 4'hF; tag = "R4 end";
                end
                if (poke) tag = {"R11 ", tag};
                check(tag, "dat_oe", 32'(dat_oe), 32'(act));
                check(tag, "dat_out", 32'(dat_out & act), 32'(e & act));
            end
            tok = (b == bad_blk) ? 3'b101 : 3'b010;
            @(negedge clk);
            check("R6", "oe after end", 32'(dat_oe), 0);
            @(negedge clk);
            dat_in = 4'hE;
            check("R6", "oe token start", 32'(dat_oe), 0);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                dat_in = {3'b111, tok[2 - k]};
                check("R6", "oe token", 32'(dat_oe), 0);
            end
            @(negedge clk);
            dat_in = 4'hF;
            check("R6", "oe token end", 32'(dat_oe), 0);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                dat_in = 4'hE;
                check("R6", "oe during card busy", 32'(dat_oe), 0);
            end
            @(negedge clk);
            dat_in = 4'hF;
            check("R6", "oe busy release", 32'(dat_oe), 0);
        end
        @(negedge clk);
        check("R10", "done pulse", 32'(done), 1);
        check("R10", "busy low at end", 32'(busy), 0);
        check("R7", "wr_crc_ok", 32'(wr_crc_ok), (bad_blk < 0) ? 1 : 0);
        check("R7", "rd_crc_ok after write", 32'(rd_crc_ok), 0);
        @(negedge clk);
        check("R10", "done single cycle", 32'(done), 0);
    endtask

    task automatic rd_step(input logic [3:0] v);
        @(negedge clk);
        dat_in = v;
        check("R8", "oe in read", 32'(dat_oe), 0);
        if (buf_we) begin
            check("R8", "buffer address", 32'(buf_waddr), 32'(wr_seen));
            check("R3", "buffer byte", 32'(buf_wdata), 32'(src_mem[wr_seen]));
            wr_seen++;
        end
    endtask

    task automatic do_read(input bit wide, input int bytes, input int nblk,
                           input int bad_blk, input int bad_lane);
        int          nsym = wide ? bytes * 2 : bytes * 8;
        logic [15:0] c [4];
        logic [3:0]  v;
        wr_seen = 0;
        @(negedge clk);
        cfg_read = 1'b1;
        cfg_wide = wide;
        cfg_line_bits = LBITS_W'(bytes * 8 + 15 * (wide ? 4 : 1));
        cfg_repeat = CNT_W'(nblk - 1);
        start = 1'b1;
        dat_in = 4'hF;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", 32'(busy), 1);
        for (int b = 0; b < nblk; b++) begin
            for (int l = 0; l < 4; l++) c[l] = ref_crc(l, wide, b * bytes, bytes);
            rd_step(4'hF);
            rd_step(4'hF);
            rd_step(4'h0);
            for (int i = 0; i < nsym; i++) rd_step(data_sym(wide, b * bytes, i));
            for (int k = 0; k < 16; k++) begin
                v = 4'hF;
                for (int l = 0; l < 4; l++) if (wide || l == 0) v[l] = c[l][15 - k];
                if (b == bad_blk && k == 3) v[bad_lane] = ~v[bad_lane];
                rd_step(v);
            end
            rd_step(4'hF);
        end
        @(negedge clk);
        check("R10", "done pulse", 32'(done), 1);
        check("R10", "busy low at end", 32'(busy), 0);
        check("R9", "rd_crc_ok", 32'(rd_crc_ok), (bad_blk < 0) ? 1 : 0);
        check("R9", "wr_crc_ok after read", 32'(wr_crc_ok), 0);
        check("R2", "bytes stored", 32'(wr_seen), 32'(nblk * bytes));
        @(negedge clk);
        check("R10", "done single cycle", 32'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) src_mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy", 32'(busy), 0);
        check("R1", "done", 32'(done), 0);
        check("R1", "dat_oe", 32'(dat_oe), 0);
        check("R1", "buf_we", 32'(buf_we), 0);
        check("R1", "status", 32'({rd_crc_ok, wr_crc_ok}), 0);

        do_write(1'b0, 8, 1, 2, -1, 1'b0);    // R2 R4 1-bit single block
        do_write(1'b1, 16, 3, 2, -1, 1'b1);   // R11 strobe during 4-bit burst
        do_write(1'b1, 4, 2, 3, 1, 1'b0);     // R7 rejected token on block 1
        do_write(1'b0, 2, 2, 0, -1, 1'b0);    // R4 zero gap acts as one
        do_read(1'b0, 8, 2, -1, 0);           // R8 1-bit two blocks
        do_read(1'b1, 512, 1, -1, 0);         // R2 full-size block
        do_read(1'b1, 16, 2, 1, 2);           // R9 bad CRC on line 2
        do_read(1'b0, 4, 1, 0, 0);            // R9 bad CRC 1-bit
        do_write(1'b1, 8, 1, 2, -1, 1'b0);    // R10 status cleared by start

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule